// File: doc/BRIEF.md
# Transmit Chunk Frame Extractor

This block sits on the device side of a chunked host-to-device serial link and receives 32-bit words that have already been deserialized. The words are grouped into fixed slots. Each slot holds one header word and then a payload of `PAYLOAD_WORDS` words (64 bytes by default). The block checks the header's odd parity and decodes its fields. It then walks the payload byte by byte and emits only the bytes that belong to a frame, one byte per cycle, to a downstream MAC. Start, end and abort markers travel with the bytes.

The header tells the block where frames begin and end. A start flag comes with a word offset to the frame's first byte. An end flag comes with a byte offset to the frame's last byte. A data-valid flag gates the whole payload. A frame may span many slots. One slot may hold the end of one frame and the start of the next. The block also reports each accepted header on side outputs: the even/odd sequence bit, the no-receive request and the timestamp-capture selector. It raises a one-cycle pulse for every header whose parity fails.

Words are expected no more often than once every four cycles, since each word drains as four byte beats. The host's transaction boundary is marked by `xferActive`. Dropping it realigns the block so that the next word is taken as a header.

Top module: `txChunkExtract`

## Requirements
- R1: The first word accepted (`xferActive` and `wordValid` both high) after reset, or after `xferActive` has been low, is a header. The next `PAYLOAD_WORDS` accepted words are payload, and the word after them is again a header.
- R2: A header whose 32 bits do not have an odd number of ones raises `hdrBad` for exactly one cycle, in the cycle after the header is accepted. None of that slot's payload bytes is emitted, and the open/closed frame state is left as it was.
- R3: A header with good parity and bit 31 = 1 raises `hdrOk` for one cycle after acceptance. From then on, `seqBit` shows header bit 30, `noRxReq` shows bit 29, and `tsSel` shows bits 7:6 (00 none, 01/10/11 capture slot A/B/C).
- R4: When header bit 21 (data valid) is 0, no payload byte of the slot is emitted, whatever bits 20 and 14 say, and a frame that is open stays open.
- R5: When bit 20 is set, the payload byte at index 4 × bits 19:16 is emitted with `byteSof` high, and the following bytes are emitted as part of the frame.
- R6: When bit 14 is set and a frame is open at payload byte index bits 13:8, that byte is emitted with `byteEof` high. No further byte is emitted until the next start.
- R7: Payload bytes leave in ascending index order, most significant byte of each word first. Byte lane k of a word accepted at clock edge t is presented after edge t + k. Words arrive at least four cycles apart.
- R8: If one slot has both flags set and the end index is below the start index, the open frame ends at the end index and a new frame starts at the start index, in that order.
- R9: A start while a frame is still open raises `frameAbort` together with the new frame's `byteSof` byte. This signals that the earlier, unfinished frame is dropped.
- R10: A header with good parity and bit 31 = 0 (a control command) makes the block ignore all words until `xferActive` goes low. It emits no bytes and raises neither header flag, and an open frame stays open.
- R11: An end flag when no frame is open, and payload bytes outside any frame, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferActive | input | 1 | High while a host transaction is in progress |
| wordValid | input | 1 | A deserialized word is present on wordData |
| wordData | input | 32 | Header or payload word |
| byteValid | output | 1 | A frame byte is presented |
| byteData | output | 8 | Frame byte |
| byteSof | output | 1 | First byte of a frame |
| byteEof | output | 1 | Last byte of a frame |
| frameAbort | output | 1 | With byteSof: the previously open frame is dropped |
| hdrOk | output | 1 | One-cycle pulse per good data header |
| hdrBad | output | 1 | One-cycle pulse per header with a parity error |
| seqBit | output | 1 | Sequence bit of the last good data header |
| noRxReq | output | 1 | No-receive request of the last good data header |
| tsSel | output | 2 | Timestamp capture selector of the last good data header |

## Verification
Two pairs of events can meet on a single byte beat. The first is the end of one frame and the start of another when both markers fall in one slot. The second is an abort of an open frame and the start of its successor. Directed slots provoke both orders: end index below start index, and start while a frame is open with the end later in the same slot. The random slots also hit them by chance. A bench model walks every slot byte by byte, in index order, and predicts the marker combination on each emitted byte. The whole emitted stream, markers included, is compared against that prediction.

// File: rtl/txcx_pkg.sv
package txcx_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // header bit positions that the decoder relies on
  localparam int HB_DATA  = 31;
  localparam int HB_SEQ   = 30;
  localparam int HB_NORX  = 29;
  localparam int HB_VALID = 21;
  localparam int HB_START = 20;
  localparam int HB_SWO   = 16;  // 4-bit word offset
  localparam int HB_END   = 14;
  localparam int HB_EBO   = 8;   // 6-bit byte offset
  localparam int HB_TS    = 6;   // 2-bit capture selector

  typedef struct packed {
    logic             load;
    logic [LANES-1:0] emit;
    logic [LANES-1:0] sof;
    logic [LANES-1:0] eof;
    logic [LANES-1:0] abort;
  } laneCtl_t;
endpackage

// File: rtl/txcx_ctrl.sv
module txcx_ctrl
  import txcx_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferActive,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output laneCtl_t          ctl,
  output logic              hdrOk,
  output logic              hdrBad,
  output logic              seqBit,
  output logic              noRxReq,
  output logic [1:0]        tsSel
);
  localparam int CW = $clog2(PAYLOAD_WORDS + 1);
  localparam int IW = $clog2(PAYLOAD_WORDS * LANES) + 1;

  logic [CW-1:0] wordCnt;
  logic          halted;
  logic          chunkUse;
  logic          svR, evR;
  logic [3:0]    swoR;
  logic [5:0]    eboR;
  logic          inFrame;
  logic          openNext;
  logic          accept;
  logic          parOk;

  assign accept = xferActive && wordValid && !halted;
  assign parOk  = ^wordData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt  <= '0;
      halted   <= 1'b0;
      chunkUse <= 1'b0;
      svR      <= 1'b0;
      evR      <= 1'b0;
      swoR     <= '0;
      eboR     <= '0;
      inFrame  <= 1'b0;
      hdrOk    <= 1'b0;
      hdrBad   <= 1'b0;
      seqBit   <= 1'b0;
      noRxReq  <= 1'b0;
      tsSel    <= '0;
    end else begin
      hdrOk  <= 1'b0;
      hdrBad <= 1'b0;
      if (!xferActive) begin
        wordCnt <= '0;
        halted  <= 1'b0;
      end else if (accept) begin
        if (wordCnt == '0) begin
          if (!parOk) begin
            wordCnt  <= CW'(1);
            chunkUse <= 1'b0;
            hdrBad   <= 1'b1;
          end else if (wordData[HB_DATA]) begin
            wordCnt  <= CW'(1);
            chunkUse <= wordData[HB_VALID];
            svR      <= wordData[HB_START];
            swoR     <= wordData[HB_SWO +: 4];
            evR      <= wordData[HB_END];
            eboR     <= wordData[HB_EBO +: 6];
            hdrOk    <= 1'b1;
            seqBit   <= wordData[HB_SEQ];
            noRxReq  <= wordData[HB_NORX];
            tsSel    <= wordData[HB_TS +: 2];
          end else begin
            halted <= 1'b1;
          end
        end else begin
          wordCnt <= (wordCnt == CW'(PAYLOAD_WORDS)) ? '0 : wordCnt + 1'b1;
          inFrame <= openNext;
        end
      end
    end
  end

  // per-lane frame walk for the payload word being accepted
  always_comb begin
    logic          open;
    logic          st, en, act;
    logic [IW-1:0] wIdx, bIdx, startIdx, endIdx;
    ctl      = '0;
    ctl.load = accept && (wordCnt != '0);
    open     = inFrame;
    wIdx     = IW'(wordCnt - 1'b1);
    startIdx = IW'({swoR, 2'b00});
    endIdx   = IW'(eboR);
    for (int l = 0; l < LANES; l++) begin
      bIdx = wIdx * IW'(LANES) + IW'(l);
      st   = chunkUse && svR && (bIdx == startIdx);
      en   = chunkUse && evR && (bIdx == endIdx);
      act  = open || st;
      if (chunkUse) begin
        ctl.emit[l]  = act;
        ctl.sof[l]   = st;
        ctl.eof[l]   = en && act;
        ctl.abort[l] = st && open;
        open         = act && !en;
      end
    end
    openNext = open;
  end

  // R1
  word_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CW'(PAYLOAD_WORDS));
  // R2
  bad_hdr_drops_chunk_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrBad |-> (!chunkUse && !hdrOk));
  // R4
  invalid_chunk_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !chunkUse) |-> (ctl.emit == '0));
  // R9
  abort_with_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> ((ctl.abort & ~ctl.sof) == '0));
  // R10
  halted_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !ctl.load);
endmodule

// File: rtl/txcx_dpath.sv
module txcx_dpath
  import txcx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [WORD_W-1:0] wordData,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              byteSof,
  output logic              byteEof,
  output logic              frameAbort
);
  localparam int LW = $clog2(LANES);

  logic [WORD_W-1:0] wordR;
  logic [LANES-1:0]  emitR, sofR, eofR, abortR;
  logic              busy;
  logic [LW-1:0]     lane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordR  <= '0;
      emitR  <= '0;
      sofR   <= '0;
      eofR   <= '0;
      abortR <= '0;
      busy   <= 1'b0;
      lane   <= '0;
    end else if (ctl.load) begin
      wordR  <= wordData;
      emitR  <= ctl.emit;
      sofR   <= ctl.sof;
      eofR   <= ctl.eof;
      abortR <= ctl.abort;
      busy   <= 1'b1;
      lane   <= '0;
    end else if (busy) begin
      if (lane == LW'(LANES - 1)) busy <= 1'b0;
      else                        lane <= lane + 1'b1;
    end
  end

  always_comb begin
    byteValid  = busy && emitR[lane];
    byteSof    = byteValid && sofR[lane];
    byteEof    = byteValid && eofR[lane];
    frameAbort = byteValid && abortR[lane];
    byteData   = wordR[8 * (LANES - 1 - int'(lane)) +: 8];
  end

  // R7
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (!busy || lane == LW'(LANES - 1)));
  // R6
  eof_closes_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteEof) |=> (!byteValid || byteSof));
endmodule

// File: rtl/txChunkExtract.sv
module txChunkExtract
  import txcx_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferActive,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  output logic        byteValid,
  output logic [7:0]  byteData,
  output logic        byteSof,
  output logic        byteEof,
  output logic        frameAbort,
  output logic        hdrOk,
  output logic        hdrBad,
  output logic        seqBit,
  output logic        noRxReq,
  output logic [1:0]  tsSel
);
  laneCtl_t ctl;

  txcx_ctrl #(.PAYLOAD_WORDS(PAYLOAD_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .xferActive(xferActive), .wordValid(wordValid),
    .wordData(wordData), .ctl(ctl), .hdrOk(hdrOk), .hdrBad(hdrBad),
    .seqBit(seqBit), .noRxReq(noRxReq), .tsSel(tsSel)
  );

  txcx_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordData(wordData),
    .byteValid(byteValid), .byteData(byteData), .byteSof(byteSof),
    .byteEof(byteEof), .frameAbort(frameAbort)
  );
endmodule

// File: tb/txChunkExtract_test.sv
`timescale 1ns/1ps
module txChunkExtract_test;
  logic clk = 1'b0, rstN = 1'b0, xferActive = 1'b0, wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic byteValid, byteSof, byteEof, frameAbort, hdrOk, hdrBad, seqBit, noRxReq;
  logic [7:0] byteData;
  logic [1:0] tsSel;

  txChunkExtract uut (
    .clk(clk), .rstN(rstN), .xferActive(xferActive), .wordValid(wordValid),
    .wordData(wordData), .byteValid(byteValid), .byteData(byteData),
    .byteSof(byteSof), .byteEof(byteEof), .frameAbort(frameAbort),
    .hdrOk(hdrOk), .hdrBad(hdrBad), .seqBit(seqBit), .noRxReq(noRxReq),
    .tsSel(tsSel)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0, okCnt = 0, badCnt = 0;
  bit finished = 0;
  logic [31:0] pay [16];
  logic [10:0] expQ[$], gotQ[$];
  bit tbOpen = 0, tbHalted = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) gotQ.push_back({frameAbort, byteSof, byteEof, byteData});
      if (hdrOk) okCnt++;
      if (hdrBad) badCnt++;
    end
  end

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHdr(bit dnc, bit seq, bit norx, bit dv, bit sv,
      logic [3:0] swo, bit ev, logic [5:0] ebo, logic [1:0] ts, bit badPar);
    logic [31:0] h;
    h = {dnc, seq, norx, 5'b0, 2'b0, dv, sv, swo, 1'b0, ev, ebo, ts, 5'b0, 1'b0};
    h[0] = ~(^h[31:1]) ^ badPar;
    return h;
  endfunction

  task automatic sendWord(input logic [31:0] w);
    wordData  = w;
    wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic endXfer();
    xferActive = 1'b0;
    repeat (2) @(negedge clk);
    xferActive = 1'b1;
    tbHalted = 0;
  endtask

  task automatic randPay();
    for (int i = 0; i < 16; i++) pay[i] = $urandom;
  endtask

  task automatic runChunk(input logic [31:0] hdr, input int nWords, input string req);
    int ok0, bad0;
    bit parOk, wasHalted, expOk, expBad;
    ok0 = okCnt; bad0 = badCnt;
    parOk = ^hdr;
    wasHalted = tbHalted;
    expOk  = !wasHalted && parOk && hdr[31];
    expBad = !wasHalted && !parOk;
    if (!wasHalted) begin
      if (parOk && !hdr[31]) tbHalted = 1;
      else if (parOk && hdr[21]) begin
        for (int b = 0; b < nWords * 4; b++) begin
          bit st, en, act;
          st  = hdr[20] && (b == int'(hdr[19:16]) * 4);
          en  = hdr[14] && (b == int'(hdr[13:8]));
          act = tbOpen || st;
          if (act) expQ.push_back({st && tbOpen, st, en, pay[b/4][31 - 8*(b%4) -: 8]});
          tbOpen = act && !en;
        end
      end
    end
    sendWord(hdr);
    check((okCnt - ok0) == int'(expOk) && (badCnt - bad0) == int'(expBad),
          {req, " R2 R3 header flags"}, {okCnt - ok0, badCnt - bad0}, {32'(expOk), 32'(expBad)});
    if (expOk)
      check(seqBit == hdr[30] && noRxReq == hdr[29] && tsSel == hdr[7:6],
            {req, " R3 header fields"}, {seqBit, noRxReq, tsSel}, {hdr[30], hdr[29], hdr[7:6]});
    for (int i = 0; i < nWords; i++) sendWord(pay[i]);
    @(negedge clk);
    begin
      bit same;
      int bad;
      same = (gotQ.size() == expQ.size());
      bad = -1;
      if (same) for (int i = 0; i < gotQ.size(); i++) if (gotQ[i] !== expQ[i] && bad < 0) bad = i;
      if (bad >= 0) same = 0;
      if (bad >= 0)
        check(same, {req, " byte stream"}, 32'(gotQ[bad]), 32'(expQ[bad]));
      else
        check(same, {req, " byte stream"}, gotQ.size(), expQ.size());
    end
    gotQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!byteValid && !hdrOk && !hdrBad && !seqBit && !noRxReq && tsSel == 2'b00,
          "R1 reset outputs", {byteValid, hdrOk, hdrBad, seqBit, noRxReq, tsSel}, 0);
    xferActive = 1'b1;
    @(negedge clk);

    // R5 R6 R7: one full-payload frame, MSB first
    for (int i = 0; i < 16; i++) pay[i] = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
    runChunk(mkHdr(1, 1, 1, 1, 1, 4'd0, 1, 6'd63, 2'b10, 0), 16, "R5 R6 R7 full frame");
    // R6: frame spanning two slots
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd3, 0, 6'd0, 2'b01, 0), 16, "R5 span start");
    randPay(); runChunk(mkHdr(1, 1, 0, 1, 0, 4'd0, 1, 6'd10, 2'b11, 0), 16, "R6 span end");
    // R4: invalid payload inside an open frame
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd0, 0, 6'd0, 2'b00, 0), 16, "R4 open");
    randPay(); runChunk(mkHdr(1, 1, 0, 0, 1, 4'd2, 1, 6'd9, 2'b00, 0), 16, "R4 dv zero");
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 0, 4'd0, 1, 6'd2, 2'b00, 0), 16, "R4 close");
    // R2: parity error drops the slot
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd1, 1, 6'd30, 2'b00, 1), 16, "R2 bad parity");
    // R8: end before start in one slot
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd0, 0, 6'd0, 2'b00, 0), 16, "R8 open");
    randPay(); runChunk(mkHdr(1, 1, 0, 1, 1, 4'd4, 1, 6'd5, 2'b00, 0), 16, "R8 end then start");
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 0, 4'd0, 1, 6'd0, 2'b00, 0), 16, "R8 close");
    // R9: start while open
    randPay(); runChunk(mkHdr(1, 1, 0, 1, 1, 4'd0, 0, 6'd0, 2'b00, 0), 16, "R9 open");
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd8, 1, 6'd40, 2'b00, 0), 16, "R9 abort");
    // R11: end with no open frame
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 0, 4'd0, 1, 6'd7, 2'b00, 0), 16, "R11 stray end");
    // R10: control header halts until transaction end
    randPay(); runChunk(mkHdr(0, 0, 0, 1, 1, 4'd0, 1, 6'd20, 2'b00, 0), 16, "R10 control");
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd0, 1, 6'd20, 2'b00, 0), 16, "R10 halted words");
    endXfer();
    randPay(); runChunk(mkHdr(1, 1, 0, 1, 1, 4'd2, 1, 6'd50, 2'b01, 0), 16, "R10 resumed");
    // R1: partial slot then realignment on transaction end
    randPay(); runChunk(mkHdr(1, 0, 0, 1, 1, 4'd1, 0, 6'd0, 2'b00, 0), 5, "R1 partial");
    endXfer();
    randPay(); runChunk(mkHdr(1, 1, 1, 1, 0, 4'd0, 1, 6'd3, 2'b10, 0), 16, "R1 realigned");

    // constrained random slots
    for (int k = 0; k < 40; k++) begin
      bit dnc;
      dnc = ($urandom % 10) != 0;
      randPay();
      runChunk(mkHdr(dnc, 1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
                     4'($urandom), 1'($urandom), 6'($urandom), 2'($urandom),
                     ($urandom % 8) == 0), 16, "R5 R6 R8 R9 random");
      if (tbHalted) endXfer();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule